// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating and Automatic Request-to-Send

This block serializes host bytes onto an asynchronous serial line. The host writes a byte into a one-entry holding stage. A separate shift stage frames and sends it one bit per bit-time enable pulse. When a frame ends and the holding stage is already full, the next byte moves into the shift stage at the same bit-time edge, so consecutive characters follow with no idle time between them.

Two handshake features can each be switched on by a mode input. With clear-to-send gating on, the transmitter looks at the active-low clear-to-send input only at the edge where it would begin a character. It starts the character only when that input is low. Otherwise the line stays at mark and the byte waits in the holding stage. A change on that input while a character is being shifted does not affect the character.

The active-low request-to-send output is normally controlled only by the software assert and negate commands. With automatic negation on, the output is negated one bit time after all data has left the transmitter. A host write during that one-bit wait cancels the negation.

Top module: `uart_tx_flow`

## Requirements
- R1: While reset is high and in the first cycle after it, txd is 1, rts_n is 1, thr_empty is 1 and tx_empty is 1.
- R2: A frame is one start bit (0), then 8 data bits with the least significant bit first, then one stop bit (1). Every bit lasts exactly one bit_en period. txd changes only in the cycle after a bit_en pulse.
- R3: A host write (wr_valid high for one cycle) is taken only while thr_empty is 1. A write while the holding stage is full is dropped and never appears on txd.
- R4: When the holding stage is full at the end of a stop bit and sending is allowed, the next start bit begins at that same bit_en edge. Frame starts are then exactly 10 bit periods apart.
- R5: With cts_mode at 0, the level of cts_n has no effect on transmission.
- R6: With cts_mode at 1, a character starts only at a bit_en edge where cts_n is 0. While cts_n is 1, txd stays 1, thr_empty stays 0, and the byte waits until cts_n falls.
- R7: With cts_mode at 1, a rise of cts_n after a start bit has begun does not change the character being sent.
- R8: A pulse on rts_set drives rts_n to 0 in the next cycle. A pulse on rts_clr drives rts_n to 1 in the next cycle. When both are high together, rts_clr wins.
- R9: With auto_rts_mode at 0, rts_n does not change when the transmitter drains.
- R10: With auto_rts_mode at 1 and rts_n at 0, rts_n rises at the first bit_en edge after tx_empty rises, which is 8 cycles after the rise for a bit period of 8 cycles. It then stays at 1 until rts_set.
- R11: A host write during the one-bit wait of R10 cancels the pending negation, and rts_n stays 0 while the new byte is sent.
- R12: thr_empty is 1 exactly when the holding stage is empty. tx_empty is 1 only when both stages are empty and no bit is being sent, and txd is 1 whenever tx_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Host byte |
| cts_n | input | 1 | Clear-to-send, active low |
| cts_mode | input | 1 | 1 = gate each character on cts_n |
| auto_rts_mode | input | 1 | 1 = negate rts_n automatically after drain |
| rts_set | input | 1 | Software command: assert request-to-send |
| rts_clr | input | 1 | Software command: negate request-to-send |
| txd | output | 1 | Serial output, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| thr_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Both stages empty and line idle |

## Verification
The hardest case to reach is a host write that lands inside the one-bit window between the transmitter draining and the automatic negation of request-to-send. The stimulus first sends a byte with automatic negation off. It turns automatic negation on while that byte is in flight, waits for tx_empty to rise, and writes a second byte three cycles later. The gating case is reached by holding cts_n high with a byte waiting, then trying a second write that must be dropped. A scoreboard of expected bytes catches any extra or damaged frame.

// File: rtl/uart_tx_flow_pkg.sv
package uart_tx_flow_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_BUSY = 1'b1} sh_state_t;
endpackage

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cts_mode,
  input  logic              cts_n,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sh_state_t          state;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   cnt;
  logic               last_bit;
  logic               may_start;

  assign busy      = (state == SH_BUSY);
  assign last_bit  = busy && (cnt == CNT_W'(1));
  // clear-to-send is only looked at on a character boundary
  assign may_start = hold_full && (!cts_mode || !cts_n);
  assign take      = bit_en && may_start && (!busy || last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SH_IDLE;
      frame <= '1;
      cnt   <= '0;
      txd   <= 1'b1;
    end else if (bit_en) begin
      if (take) begin
        state <= SH_BUSY;
        frame <= {1'b1, hold_data, 1'b0};
        cnt   <= CNT_W'(FRAME_W);
        txd   <= 1'b0;
      end else if (last_bit) begin
        state <= SH_IDLE;
        txd   <= 1'b1;
      end else if (busy) begin
        frame <= {1'b1, frame[FRAME_W-1:1]};
        cnt   <= cnt - CNT_W'(1);
        txd   <= frame[1];
      end
    end
  end
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic auto_mode,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic wr_valid,
  input  logic tx_empty,
  output logic rts_n
);
  logic rts_q;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_q <= 1'b0;
      pend  <= 1'b0;
    end else if (sw_clr) begin
      rts_q <= 1'b0;
      pend  <= 1'b0;
    end else if (sw_set) begin
      rts_q <= 1'b1;
      pend  <= 1'b0;
    end else if (!auto_mode || !tx_empty || wr_valid) begin
      pend  <= 1'b0;
    end else if (pend && bit_en) begin
      rts_q <= 1'b0;
      pend  <= 1'b0;
    end else if (rts_q) begin
      pend  <= 1'b1;
    end
  end

  assign rts_n = ~rts_q;
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cts_n,
  input  logic              cts_mode,
  input  logic              auto_rts_mode,
  input  logic              rts_set,
  input  logic              rts_clr,
  output logic              txd,
  output logic              rts_n,
  output logic              thr_empty,
  output logic              tx_empty
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;

  tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take), .full(hold_full), .data(hold_data)
  );

  tx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .hold_full(hold_full),
    .hold_data(hold_data), .cts_mode(cts_mode), .cts_n(cts_n),
    .take(take), .busy(busy), .txd(txd)
  );

  rts_ctrl rts_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .auto_mode(auto_rts_mode),
    .sw_set(rts_set), .sw_clr(rts_clr), .wr_valid(wr_valid),
    .tx_empty(tx_empty), .rts_n(rts_n)
  );

  assign thr_empty = ~hold_full;
  assign tx_empty  = ~hold_full & ~busy;
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic wr_valid,
  input logic cts_n,
  input logic cts_mode,
  input logic auto_rts_mode,
  input logic rts_set,
  input logic rts_clr,
  input logic txd,
  input logic rts_n,
  input logic thr_empty,
  input logic tx_empty
);
  a_r2_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(bit_en));

  a_r3_fill_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(thr_empty) |-> $past(wr_valid));

  a_r6_cts_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty) |-> ($past(bit_en) && (!$past(cts_mode) || !$past(cts_n))));

  a_r8_assert_by_sw: assert property (@(posedge clk) disable iff (rst)
    $fell(rts_n) |-> $past(rts_set));

  a_r10_negate_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rts_n) |-> ($past(rts_clr) ||
                      ($past(auto_rts_mode) && $past(bit_en) && $past(tx_empty))));

  a_r12_empty_implies_hold: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> thr_empty);

  a_r12_idle_mark: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);
endmodule

bind uart_tx_flow uart_tx_flow_chk chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .wr_valid(wr_valid),
  .cts_n(cts_n), .cts_mode(cts_mode), .auto_rts_mode(auto_rts_mode),
  .rts_set(rts_set), .rts_clr(rts_clr), .txd(txd), .rts_n(rts_n),
  .thr_empty(thr_empty), .tx_empty(tx_empty)
);

// File: tb/uart_tx_flow_tb_top.sv
`timescale 1ns/1ps
module uart_tx_flow_tb_top;
  localparam int BIT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cts_n = 1'b1;
  logic       cts_mode = 1'b0;
  logic       auto_rts_mode = 1'b0;
  logic       rts_set = 1'b0;
  logic       rts_clr = 1'b0;
  logic       txd, rts_n, thr_empty, tx_empty;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rx_count = 0;
  int prev_start = 0;
  int last_start = 0;
  logic [7:0] exp_q[$];

  uart_tx_flow #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .cts_n(cts_n), .cts_mode(cts_mode),
    .auto_rts_mode(auto_rts_mode), .rts_set(rts_set), .rts_clr(rts_clr),
    .txd(txd), .rts_n(rts_n), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-time enable: one cycle in every BIT
  initial begin
    forever begin
      repeat (BIT - 1) @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  end

  // monitor: decodes frames from txd and pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd == 1'b0) begin
        logic [7:0] got;
        prev_start = last_start;
        last_start = cyc;
        repeat (3) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit", txd, 1);
        rx_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected frame", got, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(got == e, "R2 frame data", got, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    do @(negedge clk); while (!thr_empty);
    wr_valid = 1'b1;
    wr_data  = b;
    exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && exp_q.size() == 0));
  endtask

  task automatic wait_start();
    do @(negedge clk); while (txd != 1'b0);
  endtask

  task automatic pulse_set();
    @(negedge clk); rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); rts_clr = 1'b1; @(negedge clk); rts_clr = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    bit ok;
    int cnt;
    repeat (4) @(negedge clk);
    check(txd && rts_n && thr_empty && tx_empty, "R1 reset state",
          {txd, rts_n, thr_empty, tx_empty}, 15);
    rst = 1'b0;
    @(negedge clk);
    check(txd && rts_n && thr_empty && tx_empty, "R1 after reset",
          {txd, rts_n, thr_empty, tx_empty}, 15);

    // R5: cts ignored when gating is off; R4 back-to-back
    cts_n = 1'b1;
    send(8'hA5);
    send(8'h3C);
    wait_idle();
    check(last_start - prev_start == 10 * BIT, "R4 no gap", last_start - prev_start, 10 * BIT);
    check(rx_count == 2, "R5 cts ignored", rx_count, 2);
    foreach (exp_q[i]) ;
    send(8'h00); send(8'hFF); send(8'h01); send(8'h80);
    wait_idle();
    check(rx_count == 6, "R2 pattern frames", rx_count, 6);
    check(rts_n == 1'b1, "R9 rts untouched", rts_n, 1);

    // R12 flags mid-frame
    send(8'h55);
    wait_start();
    repeat (2) @(negedge clk);
    check(thr_empty == 1'b1 && tx_empty == 1'b0, "R12 flags while shifting",
          {thr_empty, tx_empty}, 2);
    wait_idle();

    // R6 gating and R3 dropped write
    cts_mode = 1'b1;
    cts_n = 1'b1;
    base = rx_count;
    send(8'h96);
    ok = 1'b1;
    repeat (15 * BIT) begin
      @(negedge clk);
      if (txd != 1'b1) ok = 1'b0;
    end
    check(ok, "R6 line held at mark", ok, 1);
    check(thr_empty == 1'b0, "R6 byte waits", thr_empty, 0);
    wr_valid = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    wr_valid = 1'b0;
    check(thr_empty == 1'b0, "R3 full write dropped", thr_empty, 0);
    cts_n = 1'b0;
    wait_idle();
    repeat (15 * BIT) @(negedge clk);
    check(rx_count == base + 1, "R3 only one frame", rx_count, base + 1);

    // R7 cts rise mid-character
    base = rx_count;
    send(8'hC3);
    wait_start();
    repeat (20) @(negedge clk);
    cts_n = 1'b1;
    wait_idle();
    check(rx_count == base + 1, "R7 char completes", rx_count, base + 1);
    cts_n = 1'b0;
    cts_mode = 1'b0;

    // R8 software commands
    pulse_set();
    check(rts_n == 1'b0, "R8 set", rts_n, 0);
    pulse_clr();
    check(rts_n == 1'b1, "R8 clear", rts_n, 1);
    pulse_set();
    @(negedge clk); rts_set = 1'b1; rts_clr = 1'b1;
    @(negedge clk); rts_set = 1'b0; rts_clr = 1'b0;
    check(rts_n == 1'b1, "R8 clear wins", rts_n, 1);
    pulse_set();

    // R9 auto off keeps rts asserted after drain
    send(8'h5A);
    wait_idle();
    repeat (5 * BIT) @(negedge clk);
    check(rts_n == 1'b0, "R9 no auto negate", rts_n, 0);

    // R10 auto negation timing
    send(8'h42);
    wait_start();
    auto_rts_mode = 1'b1;
    do @(negedge clk); while (!tx_empty);
    cnt = 0;
    while (rts_n == 1'b0 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == BIT, "R10 one bit after drain", cnt, BIT);
    repeat (6 * BIT) @(negedge clk);
    check(rts_n == 1'b1, "R10 stays negated", rts_n, 1);

    // R11 write during wait cancels negation
    auto_rts_mode = 1'b0;
    pulse_set();
    send(8'h81);
    wait_start();
    auto_rts_mode = 1'b1;
    do @(negedge clk); while (!tx_empty);
    repeat (2) @(negedge clk);
    send(8'h7E);
    ok = 1'b1;
    do begin
      @(negedge clk);
      if (rts_n != 1'b0) ok = 1'b0;
    end while (!(tx_empty && exp_q.size() == 0));
    check(ok, "R11 negation cancelled", ok, 1);
    repeat (2 * BIT) @(negedge clk);
    check(rts_n == 1'b1, "R10 negated after second drain", rts_n, 1);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule